// File: doc/BRIEF.md
# Program Status Word Flag Unit

This block keeps the condition flags and the two control bits of a processor status word. Each cycle it can accept one ALU result (value, carry-or-borrow out, signed overflow, and an operation class) over a valid/ready input. It then updates the sign, zero, carry, overflow and equality flags according to the class. A small evaluator turns the stored flags into a taken/not-taken answer for a selected branch condition. The evaluator is combinational, so a branch sees the flags as soon as they are registered.

Four strobes set or clear the interrupt-enable and supervisor bits. These strobes are privileged. In supervisor mode they take effect at the next clock edge. In user mode they are refused. In that case the unit raises a fault pulse for one cycle, and the status word keeps its value. In the refused cycle the result input also stalls: `res_ready` is low, so the producer must hold its result and offer it again. `res_ready` is high in every other cycle.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset all five flags are 0, interrupt-enable is 0, supervisor is 1, and `priv_fault` is 0.
- R2: A result is consumed only in a cycle where `res_valid` and `res_ready` are both high. `res_ready` is low exactly in a cycle where any control strobe is asserted while the supervisor bit is 0, and high otherwise.
- R3: When an arithmetic result (`res_op` = 0) is consumed, sign takes the result's top bit, zero is set when the result is all zeros, carry takes `res_carry`, and overflow takes `res_ovf`. The equality flag is left unchanged.
- R4: When a compare result (`res_op` = 1) is consumed, sign, zero, carry and overflow update as in R3, and the equality flag is set exactly when the result (the difference of the operands) is zero.
- R5: When a logical result (`res_op` = 2) is consumed, sign and zero update as in R3. Carry, overflow and equality keep their values.
- R6: A consumed result with `res_op` = 3 changes no flag.
- R7: In supervisor mode, `ie_set`/`ie_clr` set or clear interrupt-enable and `sup_set`/`sup_clr` set or clear supervisor at the next edge. When set and clear of the same bit arrive together, clear wins.
- R8: A control strobe while the supervisor bit is 0 makes `priv_fault` high for the following cycle only. No flag or control bit changes as a result of that cycle.
- R9: `cond_true` reflects the stored flags for `cond_sel`: 0 zero, 1 not zero, 2 carry, 3 sign (negative), 4 overflow, 5 equal.
- R10: `cond_sel` values 6 and 7 give `cond_true` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | ALU result offered |
| res_ready | output | 1 | Result accepted this cycle |
| res_value | input | DATA_W | ALU result |
| res_carry | input | 1 | Carry out (add) or borrow (subtract) |
| res_ovf | input | 1 | Signed overflow of the operation |
| res_op | input | 2 | Class: 0 arithmetic, 1 compare, 2 logical, 3 no flag update |
| ie_set | input | 1 | Privileged: set interrupt-enable |
| ie_clr | input | 1 | Privileged: clear interrupt-enable |
| sup_set | input | 1 | Privileged: enter supervisor mode |
| sup_clr | input | 1 | Privileged: drop to user mode |
| cond_sel | input | 3 | Branch condition select |
| cond_true | output | 1 | Selected condition holds |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry/borrow flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_eq | output | 1 | Equality flag |
| int_enable | output | 1 | Interrupt-enable bit |
| supervisor | output | 1 | Supervisor mode bit |
| priv_fault | output | 1 | One-cycle privilege violation pulse |

## Verification
The properties assume that the inputs are settled and known at every clock edge after reset. They also assume that a producer facing a low `res_ready` treats the result as not taken, so the stability checks on the flags during a refused cycle are meaningful. The stimulus changes every input only at the falling edge. In user mode it offers results only together with a strobe when it wants to exercise the stall. Afterwards it repeats the stalled result, and the expected state follows that replay.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [1:0] {
    OP_ARITH = 2'd0,
    OP_CMP   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_NONE  = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    BR_ZERO  = 3'd0,
    BR_NZERO = 3'd1,
    BR_CARRY = 3'd2,
    BR_NEG   = 3'd3,
    BR_OVF   = 3'd4,
    BR_EQ    = 3'd5
  } br_cond_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic v;
    logic e;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{s: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0, e: 1'b0};

endpackage

// File: rtl/psw_flag_logic.sv
module psw_flag_logic
  import psw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  flags_t              cur,
  input  logic                take,
  input  logic [1:0]          op,
  input  logic [DATA_W-1:0]   value,
  input  logic                carry_in,
  input  logic                ovf_in,
  output flags_t              nxt
);
  localparam int MSB = DATA_W - 1;

  logic is_zero;
  logic top_bit;

  assign is_zero = (value == '0);
  assign top_bit = value[MSB];

  always_comb begin
    nxt = cur;
    if (take) begin
      unique case (op_class_e'(op))
        OP_ARITH: begin
          nxt.s = top_bit;
          nxt.z = is_zero;
          nxt.c = carry_in;
          nxt.v = ovf_in;
        end
        OP_CMP: begin
          nxt.s = top_bit;
          nxt.z = is_zero;
          nxt.c = carry_in;
          nxt.v = ovf_in;
          nxt.e = is_zero;
        end
        OP_LOGIC: begin
          nxt.s = top_bit;
          nxt.z = is_zero;
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/psw_priv_ctrl.sv
module psw_priv_ctrl (
  input  logic ie_q,
  input  logic sup_q,
  input  logic ie_set,
  input  logic ie_clr,
  input  logic sup_set,
  input  logic sup_clr,
  output logic violation,
  output logic ie_nxt,
  output logic sup_nxt
);
  logic any_strobe;

  assign any_strobe = ie_set | ie_clr | sup_set | sup_clr;
  assign violation  = any_strobe & ~sup_q;

  always_comb begin
    ie_nxt  = ie_q;
    sup_nxt = sup_q;
    if (sup_q) begin
      if (ie_clr)       ie_nxt = 1'b0;
      else if (ie_set)  ie_nxt = 1'b1;
      if (sup_clr)      sup_nxt = 1'b0;
      else if (sup_set) sup_nxt = 1'b1;
    end
  end
endmodule

// File: rtl/psw_cond_eval.sv
module psw_cond_eval
  import psw_pkg::*;
(
  input  flags_t     flags,
  input  logic [2:0] sel,
  output logic       taken
);
  always_comb begin
    unique case (sel)
      BR_ZERO:  taken = flags.z;
      BR_NZERO: taken = ~flags.z;
      BR_CARRY: taken = flags.c;
      BR_NEG:   taken = flags.s;
      BR_OVF:   taken = flags.v;
      BR_EQ:    taken = flags.e;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_carry,
  input  logic              res_ovf,
  input  logic [1:0]        res_op,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              sup_set,
  input  logic              sup_clr,
  input  logic [2:0]        cond_sel,
  output logic              cond_true,
  output logic              flag_sign,
  output logic              flag_zero,
  output logic              flag_carry,
  output logic              flag_ovf,
  output logic              flag_eq,
  output logic              int_enable,
  output logic              supervisor,
  output logic              priv_fault
);
  flags_t flags_q, flags_nxt;
  logic   ie_q, sup_q, fault_q;
  logic   ie_nxt, sup_nxt, violation, take;

  assign res_ready = ~violation;
  assign take      = res_valid & res_ready;

  psw_priv_ctrl u_priv (
    .ie_q      (ie_q),
    .sup_q     (sup_q),
    .ie_set    (ie_set),
    .ie_clr    (ie_clr),
    .sup_set   (sup_set),
    .sup_clr   (sup_clr),
    .violation (violation),
    .ie_nxt    (ie_nxt),
    .sup_nxt   (sup_nxt)
  );

  psw_flag_logic #(.DATA_W(DATA_W)) u_flags (
    .cur      (flags_q),
    .take     (take),
    .op       (res_op),
    .value    (res_value),
    .carry_in (res_carry),
    .ovf_in   (res_ovf),
    .nxt      (flags_nxt)
  );

  psw_cond_eval u_cond (
    .flags (flags_q),
    .sel   (cond_sel),
    .taken (cond_true)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= FLAGS_RESET;
      ie_q    <= 1'b0;
      sup_q   <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      fault_q <= violation;
      if (!violation) begin
        flags_q <= flags_nxt;
        ie_q    <= ie_nxt;
        sup_q   <= sup_nxt;
      end
    end
  end

  assign flag_sign  = flags_q.s;
  assign flag_zero  = flags_q.z;
  assign flag_carry = flags_q.c;
  assign flag_ovf   = flags_q.v;
  assign flag_eq    = flags_q.e;
  assign int_enable = ie_q;
  assign supervisor = sup_q;
  assign priv_fault = fault_q;
endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_value,
  input logic [1:0]        res_op,
  input logic              ie_set,
  input logic              ie_clr,
  input logic              sup_set,
  input logic              sup_clr,
  input logic              flag_sign,
  input logic              flag_zero,
  input logic              flag_carry,
  input logic              flag_ovf,
  input logic              flag_eq,
  input logic              int_enable,
  input logic              supervisor,
  input logic              priv_fault
);
  logic strobe;
  assign strobe = ie_set | ie_clr | sup_set | sup_clr;

  // R2: a strobe in user mode stalls the result input
  p_stall_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !supervisor) |-> !res_ready);

  // R8: refused strobe yields a fault pulse next cycle
  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !supervisor) |=> priv_fault);

  // R8: a refused cycle leaves the whole status word untouched
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !supervisor) |=> ($stable(flag_sign) && $stable(flag_zero) &&
      $stable(flag_carry) && $stable(flag_ovf) && $stable(flag_eq) &&
      $stable(int_enable) && $stable(supervisor)));

  // R5: logical results keep carry and overflow
  p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_op == 2'd2) |=>
      ($stable(flag_carry) && $stable(flag_ovf)));

  // R4: only a consumed compare may move the equality flag
  p_eq_cmp_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_ready && res_op == 2'd1) |=> $stable(flag_eq));

  // R3: zero flag tracks a consumed updating result
  p_zero_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_op != 2'd3) |=>
      (flag_zero == ($past(res_value) == '0)));

  // R6: a no-update class keeps every flag
  p_none_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_op == 2'd3) |=>
      ($stable(flag_sign) && $stable(flag_zero) && $stable(flag_carry) &&
       $stable(flag_ovf) && $stable(flag_eq)));
endmodule

bind psw_flag_unit psw_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_value  (res_value),
  .res_op     (res_op),
  .ie_set     (ie_set),
  .ie_clr     (ie_clr),
  .sup_set    (sup_set),
  .sup_clr    (sup_clr),
  .flag_sign  (flag_sign),
  .flag_zero  (flag_zero),
  .flag_carry (flag_carry),
  .flag_ovf   (flag_ovf),
  .flag_eq    (flag_eq),
  .int_enable (int_enable),
  .supervisor (supervisor),
  .priv_fault (priv_fault)
);

// File: tb/psw_flag_unit_test.sv
module psw_flag_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0, res_carry = 1'b0, res_ovf = 1'b0;
  logic [W-1:0] res_value = '0;
  logic [1:0] res_op = 2'd3;
  logic ie_set = 1'b0, ie_clr = 1'b0, sup_set = 1'b0, sup_clr = 1'b0;
  logic [2:0] cond_sel = 3'd0;
  logic res_ready, cond_true, flag_sign, flag_zero, flag_carry, flag_ovf, flag_eq;
  logic int_enable, supervisor, priv_fault;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_flag_unit #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_value(res_value), .res_carry(res_carry), .res_ovf(res_ovf), .res_op(res_op),
    .ie_set(ie_set), .ie_clr(ie_clr), .sup_set(sup_set), .sup_clr(sup_clr),
    .cond_sel(cond_sel), .cond_true(cond_true), .flag_sign(flag_sign),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
    .flag_eq(flag_eq), .int_enable(int_enable), .supervisor(supervisor),
    .priv_fault(priv_fault)
  );

  // packed expected state: {cond, fault, sup, ie, e, v, c, z, s}
  typedef struct {
    logic [8:0] st;
    string      req;
  } item_t;

  item_t exp_q[$];

  logic m_s = 0, m_z = 0, m_c = 0, m_v = 0, m_e = 0, m_ie = 0, m_sup = 1;

  function automatic logic cond_of(input logic [2:0] sel);
    case (sel)
      3'd0: return m_z;
      3'd1: return ~m_z;
      3'd2: return m_c;
      3'd3: return m_s;
      3'd4: return m_v;
      3'd5: return m_e;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model update, expected item queued
  task automatic drive(input string req, input logic v, input logic [1:0] op,
                       input logic [W-1:0] val, input logic cy, input logic ov,
                       input logic [3:0] strb, input logic [2:0] sel);
    logic viol, take;
    logic [8:0] e;
    @(negedge clk);
    res_valid = v; res_op = op; res_value = val; res_carry = cy; res_ovf = ov;
    {ie_set, ie_clr, sup_set, sup_clr} = strb;
    cond_sel = sel;
    viol = (strb != 4'b0) && !m_sup;
    take = v && !viol;
    #1;
    check({req, " ready (R2)"}, {8'b0, res_ready}, {8'b0, !viol});
    if (!viol) begin
      if (take && op != 2'd3) begin
        m_s = val[W-1];
        m_z = (val == '0);
        if (op != 2'd2) begin m_c = cy; m_v = ov; end
        if (op == 2'd1) m_e = (val == '0);
      end
      if (m_sup) begin
        if (strb[2]) m_ie = 1'b0; else if (strb[3]) m_ie = 1'b1;
        if (strb[0]) m_sup = 1'b0; else if (strb[1]) m_sup = 1'b1;
      end
    end
    e = {cond_of(sel), viol, m_sup, m_ie, m_e, m_v, m_c, m_z, m_s};
    exp_q.push_back('{st: e, req: req});
  endtask

  // monitor: compares after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check(it.req, {cond_true, priv_fault, supervisor, int_enable, flag_eq,
                       flag_ovf, flag_carry, flag_z_s()}, it.st);
      end
    end
  end

  function automatic logic [1:0] flag_z_s();
    return {flag_zero, flag_sign};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 reset", {cond_true, priv_fault, supervisor, int_enable, flag_eq,
                       flag_ovf, flag_carry, flag_zero, flag_sign}, 9'b0_0100_0000);
    // strobe order {ie_set, ie_clr, sup_set, sup_clr}
    drive("R3 arith negative",    1, 2'd0, 16'h8001, 1, 0, 4'b0, 3'd3);
    drive("R3 arith zero carry",  1, 2'd0, 16'h0000, 1, 1, 4'b0, 3'd0);
    drive("R9 cond overflow",     0, 2'd0, 16'h1234, 0, 0, 4'b0, 3'd4);
    drive("R4 compare equal",     1, 2'd1, 16'h0000, 0, 0, 4'b0, 3'd5);
    drive("R3 arith keeps eq",    1, 2'd0, 16'h0042, 0, 0, 4'b0, 3'd5);
    drive("R4 compare unequal",   1, 2'd1, 16'hFFFE, 1, 0, 4'b0, 3'd2);
    drive("R5 logic keeps c v",   1, 2'd2, 16'h0000, 0, 1, 4'b0, 3'd2);
    drive("R5 logic sign",        1, 2'd2, 16'hF000, 0, 0, 4'b0, 3'd3);
    drive("R6 no-update class",   1, 2'd3, 16'h0000, 0, 1, 4'b0, 3'd1);
    drive("R9 cond not zero",     0, 2'd3, 16'h0000, 0, 0, 4'b0, 3'd1);
    drive("R10 cond code 6",      0, 2'd3, 16'h0000, 0, 0, 4'b0, 3'd6);
    drive("R10 cond code 7",      0, 2'd3, 16'h0000, 0, 0, 4'b0, 3'd7);
    drive("R7 ie set",            0, 2'd3, 16'h0000, 0, 0, 4'b1000, 3'd0);
    drive("R7 ie clear wins",     0, 2'd3, 16'h0000, 0, 0, 4'b1100, 3'd0);
    drive("R7 ie set again",      1, 2'd0, 16'h0001, 0, 0, 4'b1000, 3'd0);
    drive("R7 drop to user",      0, 2'd3, 16'h0000, 0, 0, 4'b0001, 3'd0);
    drive("R8 user ie clear",     1, 2'd0, 16'h0000, 1, 1, 4'b0100, 3'd0);
    drive("R8 replay result",     1, 2'd0, 16'h0000, 1, 1, 4'b0, 3'd0);
    drive("R8 user sup set",      0, 2'd3, 16'h0000, 0, 0, 4'b0010, 3'd0);
    drive("R8 fault one cycle",   0, 2'd3, 16'h0000, 0, 0, 4'b0, 3'd0);
    drive("R2 user plain result", 1, 2'd1, 16'h0000, 0, 0, 4'b0, 3'd5);
    drive("R8 user both sup",     0, 2'd3, 16'h0000, 0, 0, 4'b0011, 3'd2);
    drive("R9 cond carry",        0, 2'd3, 16'h0000, 0, 0, 4'b0, 3'd2);
    @(negedge clk);
    res_valid = 1'b0;
    {ie_set, ie_clr, sup_set, sup_clr} = 4'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule